// File: doc/BRIEF.md
# Maskable Interrupt Aggregator with Retrigger Gap

This block merges four event sources into a single active-low interrupt line for a host processor. The sources are key events, general-purpose input changes, a completed keypad unlock, and event-queue overflow. Each source has a sticky status bit that latches whenever its event pulse arrives. A per-source enable decides whether that bit may pull the interrupt line low.

The host reads the status through `statusOut` and clears bits by a write-one-to-clear strobe. A mode input selects what the line does when the host clears a bit while other enabled bits are still set. In hold mode the line simply stays low. In retrigger mode the line is released for a fixed gap of `GAP_US` microseconds and then falls again. An edge-triggered host therefore sees a fresh falling edge.

The microsecond time base comes from a divider of `US_DIV` system clocks. The divider restarts when a gap begins, so every gap lasts exactly `GAP_US * US_DIV` clock cycles. A separate input can stop GPI changes from being recorded while the keypad is locked.

Top module: `irq_aggregator`

## Requirements
- R1: While reset is active and on the first cycle after it, `statusOut` is 0 and `intN` is 1.
- R2: An event pulse on `evtIn[i]` sets `statusOut[i]` at the next rising edge, and the bit stays set until it is cleared. The bit order is: 0 key event, 1 GPI change, 2 keypad unlock done, 3 overflow.
- R3: A cycle with `clrStrobe` high clears every status bit whose `clrBits` bit is 1. It leaves the bits whose `clrBits` bit is 0 unchanged.
- R4: If a set and a clear hit the same status bit in the same cycle, the bit ends up set.
- R5: Outside a retrigger gap, `intN` is 0 exactly when some status bit is set whose `srcEnable` bit is 1. A source with its enable at 0 never drives `intN` low.
- R6: While `keypadLocked` and `gpiHoldWhenLocked` are both 1, a pulse on `evtIn[1]` is ignored. When `gpiHoldWhenLocked` is 0, such a pulse is recorded even while the keypad is locked.
- R7: With `retrigMode` at 0, clearing an enabled status bit while another enabled bit stays set keeps `intN` low without a break.
- R8: With `retrigMode` at 1, a clear can remove at least one set, enabled bit while leaving some enabled bit set. `intN` is then high for exactly `GAP_US*US_DIV` cycles and falls afterwards. A further such clear during the gap restarts it.
- R9: With `retrigMode` at 1, a clear that leaves no enabled bit set starts no gap. A later event then drives `intN` low on the next cycle.
- R10: Events arriving during a gap are recorded in `statusOut`, but `intN` stays high until the gap ends.
- R11: Status bits latch even while their source is disabled. Setting the enable later drives `intN` low in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| evtIn | input | 4 | One-cycle event pulses: key, GPI, unlock done, overflow |
| keypadLocked | input | 1 | Keypad is currently locked |
| gpiHoldWhenLocked | input | 1 | 1 = drop GPI events while the keypad is locked |
| srcEnable | input | 4 | Per-source interrupt enable, same bit order as evtIn |
| retrigMode | input | 1 | 0 = hold low on clear, 1 = release for a gap and reassert |
| clrStrobe | input | 1 | Host clear write strobe |
| clrBits | input | 4 | Write-one-to-clear mask for the status bits |
| statusOut | output | 4 | Sticky status bits |
| intN | output | 1 | Active-low interrupt to the host |

## Verification
The bench builds the block with `US_DIV=4` and `GAP_US=5`, which gives a 20-cycle gap. At that size many full gaps fit in a short run. Random clears regularly land inside a running gap, which exercises the restart path and the handling of events that arrive during a gap. The exact length of one gap is also measured directly. Configuration changes every few hundred cycles move the random phase through both interrupt modes, different enable patterns, and both settings of the GPI lock filter.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  localparam int SRC_NUM = 4;
  localparam int SRC_KEY = 0;
  localparam int SRC_GPI = 1;
  localparam int SRC_UNLOCK = 2;
  localparam int SRC_OVF = 3;

  typedef struct packed {
    logic [SRC_NUM-1:0] setMask;
    logic [SRC_NUM-1:0] clrMask;
    logic               startGap;
  } ctlStrobes_t;
endpackage

// File: rtl/irq_control.sv
module irq_control
  import irq_agg_pkg::*;
(
  input  logic [SRC_NUM-1:0] evtIn,
  input  logic               keypadLocked,
  input  logic               gpiHoldWhenLocked,
  input  logic [SRC_NUM-1:0] srcEnable,
  input  logic               retrigMode,
  input  logic               clrStrobe,
  input  logic [SRC_NUM-1:0] clrBits,
  input  logic [SRC_NUM-1:0] statusQ,
  output ctlStrobes_t        strobes
);
  logic [SRC_NUM-1:0] gatedEvt;
  logic [SRC_NUM-1:0] clrMask;
  logic [SRC_NUM-1:0] nextStatus;
  logic               clearHitsEnabled;
  logic               stillPending;

  // GPI filter while the keypad is locked
  genvar gi;
  generate
    for (gi = 0; gi < SRC_NUM; gi++) begin : g_gate
      if (gi == SRC_GPI) begin : g_gpi
        assign gatedEvt[gi] = evtIn[gi] & ~(keypadLocked & gpiHoldWhenLocked);
      end else begin : g_other
        assign gatedEvt[gi] = evtIn[gi];
      end
    end
  endgenerate

  always_comb begin
    clrMask          = clrStrobe ? clrBits : '0;
    nextStatus       = (statusQ & ~clrMask) | gatedEvt;
    clearHitsEnabled = |(clrMask & statusQ & srcEnable);
    stillPending     = |(nextStatus & srcEnable);
    strobes.setMask  = gatedEvt;
    strobes.clrMask  = clrMask;
    strobes.startGap = retrigMode & clearHitsEnabled & stillPending;
  end
endmodule

// File: rtl/irq_datapath.sv
module irq_datapath
  import irq_agg_pkg::*;
#(
  parameter int US_DIV = 100,
  parameter int GAP_US = 50
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctlStrobes_t        strobes,
  output logic [SRC_NUM-1:0] statusQ,
  output logic               gapActive
);
  localparam int US_W  = $clog2(US_DIV + 1);
  localparam int GAP_W = $clog2(GAP_US + 1);

  logic [US_W-1:0]  usCnt;
  logic [GAP_W-1:0] gapCnt;
  logic             usTick;

  genvar si;
  generate
    for (si = 0; si < SRC_NUM; si++) begin : g_status
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) statusQ[si] <= 1'b0;
        else if (strobes.setMask[si]) statusQ[si] <= 1'b1;
        else if (strobes.clrMask[si]) statusQ[si] <= 1'b0;
      end
    end
  endgenerate

  assign usTick = (usCnt == US_W'(US_DIV - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      gapActive <= 1'b0;
      usCnt     <= '0;
      gapCnt    <= '0;
    end else if (strobes.startGap) begin
      gapActive <= 1'b1;
      usCnt     <= '0;
      gapCnt    <= '0;
    end else if (gapActive) begin
      if (usTick) begin
        usCnt <= '0;
        if (gapCnt == GAP_W'(GAP_US - 1)) begin
          gapActive <= 1'b0;
          gapCnt    <= '0;
        end else begin
          gapCnt <= gapCnt + 1'b1;
        end
      end else begin
        usCnt <= usCnt + 1'b1;
      end
    end
  end

  // R4
  set_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.setMask != '0) |=> ((statusQ & $past(strobes.setMask)) == $past(strobes.setMask)));

  // R3
  clear_bits_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((strobes.clrMask & ~strobes.setMask) != '0)
      |=> ((statusQ & $past(strobes.clrMask & ~strobes.setMask)) == '0));

  // R8
  gap_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    gapActive |-> (gapCnt < GAP_W'(GAP_US)) && (usCnt < US_W'(US_DIV)));
endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
  import irq_agg_pkg::*;
#(
  parameter int US_DIV = 100,
  parameter int GAP_US = 50
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [SRC_NUM-1:0] evtIn,
  input  logic               keypadLocked,
  input  logic               gpiHoldWhenLocked,
  input  logic [SRC_NUM-1:0] srcEnable,
  input  logic               retrigMode,
  input  logic               clrStrobe,
  input  logic [SRC_NUM-1:0] clrBits,
  output logic [SRC_NUM-1:0] statusOut,
  output logic               intN
);
  ctlStrobes_t        strobes;
  logic [SRC_NUM-1:0] statusQ;
  logic               gapActive;

  irq_control u_ctl (
    .evtIn            (evtIn),
    .keypadLocked     (keypadLocked),
    .gpiHoldWhenLocked(gpiHoldWhenLocked),
    .srcEnable        (srcEnable),
    .retrigMode       (retrigMode),
    .clrStrobe        (clrStrobe),
    .clrBits          (clrBits),
    .statusQ          (statusQ),
    .strobes          (strobes)
  );

  irq_datapath #(.US_DIV(US_DIV), .GAP_US(GAP_US)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .statusQ  (statusQ),
    .gapActive(gapActive)
  );

  assign statusOut = statusQ;
  assign intN      = ~(|(statusQ & srcEnable)) | gapActive;

  // R5
  masked_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    !intN |-> ((statusOut & srcEnable) != '0));

  // R10
  gap_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    gapActive |-> intN);

  // R6
  gpi_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (keypadLocked && gpiHoldWhenLocked && !statusOut[SRC_GPI]) |=> !statusOut[SRC_GPI]);

  // R1
  always_comb begin
    if (!rstN) begin
      reset_state_chk: assert (statusOut == '0 && intN == 1'b1);
    end
  end
endmodule

// File: tb/sim_irq_aggregator.sv
module sim_irq_aggregator;
  localparam int CLK_PERIOD = 10;
  localparam int US_DIV = 4;
  localparam int GAP_US = 5;
  localparam int GAP_CYC = US_DIV * GAP_US;
  localparam int WATCHDOG = 200000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [3:0] evtIn = '0, srcEnable = '0, clrBits = '0;
  logic keypadLocked = 1'b0, gpiHold = 1'b0, retrigMode = 1'b0, clrStrobe = 1'b0;
  logic [3:0] statusOut;
  logic intN;

  int checks = 0, fails = 0, cycles = 0;
  logic [3:0] mStatus = '0;
  int mGap = 0;
  bit finished = 0;

  irq_aggregator #(.US_DIV(US_DIV), .GAP_US(GAP_US)) u0 (
    .clk(clk), .rstN(rstN), .evtIn(evtIn), .keypadLocked(keypadLocked),
    .gpiHoldWhenLocked(gpiHold), .srcEnable(srcEnable), .retrigMode(retrigMode),
    .clrStrobe(clrStrobe), .clrBits(clrBits), .statusOut(statusOut), .intN(intN));

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic expIntN();
    return !(|(mStatus & srcEnable)) || (mGap > 0);
  endfunction

  function automatic void modelStep();
    logic [3:0] setM, clrM, nxt;
    setM = evtIn;
    if (keypadLocked && gpiHold) setM[1] = 1'b0;
    clrM = clrStrobe ? clrBits : 4'b0;
    nxt = (mStatus & ~clrM) | setM;
    if (retrigMode && |(clrM & mStatus & srcEnable) && |(nxt & srcEnable)) mGap = GAP_CYC;
    else if (mGap > 0) mGap--;
    mStatus = nxt;
  endfunction

  task automatic step();
    @(posedge clk);
    modelStep();
    @(negedge clk);
    evtIn = '0; clrStrobe = 1'b0; clrBits = '0;
  endtask

  task automatic checkAll(input string tag);
    checks++;
    if (statusOut !== mStatus || intN !== expIntN()) begin
      fails++;
      $display("FAIL %s: status=%b intN=%b expected status=%b intN=%b",
               tag, statusOut, intN, mStatus, expIntN());
    end
  endtask

  task automatic checkVal(input string tag, input logic [4:0] act, input logic [4:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > WATCHDOG) begin
        fails++;
        $display("FAIL watchdog: actual=%0d expected<%0d", cycles, WATCHDOG);
        finishRun();
      end
    end
  end

  initial begin
    int highRun;
    repeat (3) @(negedge clk);
    checkVal("R1 in reset", {statusOut, intN}, 5'b00001);
    rstN = 1'b1;
    @(negedge clk);
    checkVal("R1 after reset", {statusOut, intN}, 5'b00001);

    // R2: key event with enable
    srcEnable = 4'b0001;
    evtIn = 4'b0001; step();
    checkVal("R2 key set", {statusOut, intN}, 5'b00010);
    step(); step();
    checkAll("R2 sticky");

    // R5, R11: disabled overflow latches but keeps line high
    srcEnable = 4'b0000;
    evtIn = 4'b1000; step();
    checkVal("R5 disabled src", {statusOut, intN}, 5'b10011);
    srcEnable = 4'b1000; #1;
    checkVal("R11 late enable", {5'(intN)}, 5'd0);

    // R3: clear only bit 3
    clrStrobe = 1'b1; clrBits = 4'b1000; step();
    checkVal("R3 w1c", {1'b0, statusOut}, 5'b00001);
    checkAll("R3 model");

    // R4: set and clear collide on bit 2
    evtIn = 4'b0100; clrStrobe = 1'b1; clrBits = 4'b0101; step();
    checkVal("R4 set wins", {1'b0, statusOut}, 5'b00100);

    // R6: GPI filter
    keypadLocked = 1'b1; gpiHold = 1'b1;
    evtIn = 4'b0010; step();
    checkVal("R6 gpi held", {4'b0, statusOut[1]}, 5'd0);
    gpiHold = 1'b0;
    evtIn = 4'b0010; step();
    checkVal("R6 gpi recorded", {4'b0, statusOut[1]}, 5'd1);
    keypadLocked = 1'b0;
    clrStrobe = 1'b1; clrBits = 4'b1111; step();
    checkAll("R3 clear all");

    // R7: hold mode keeps line low
    srcEnable = 4'b1111; retrigMode = 1'b0;
    evtIn = 4'b0011; step();
    clrStrobe = 1'b1; clrBits = 4'b0001; step();
    highRun = 0;
    for (int i = 0; i < 30; i++) begin
      if (intN) highRun++;
      step();
    end
    checkVal("R7 no release", 5'(highRun), 5'd0);

    // R8: retrigger gap length
    retrigMode = 1'b1;
    evtIn = 4'b0001; step();
    clrStrobe = 1'b1; clrBits = 4'b0001; step();
    highRun = 0;
    for (int i = 0; i < GAP_CYC + 5; i++) begin
      if (intN) highRun++;
      checkAll("R8 gap trace");
      step();
    end
    checkVal("R8 gap length", 5'(highRun), 5'(GAP_CYC));

    // R10: event inside gap
    evtIn = 4'b0001; step();
    clrStrobe = 1'b1; clrBits = 4'b0001; step();
    repeat (3) step();
    evtIn = 4'b1000; step();
    checkVal("R10 recorded, still high", {statusOut, intN}, 5'b10101);
    repeat (GAP_CYC) step();
    checkVal("R10 low after gap", {5'(intN)}, 5'd0);

    // R9: clear all in retrigger mode
    clrStrobe = 1'b1; clrBits = 4'b1111; step();
    checkAll("R9 cleared");
    evtIn = 4'b0100; step();
    checkVal("R9 no gap", {statusOut, intN}, 5'b01000);
    clrStrobe = 1'b1; clrBits = 4'b1111; step();

    // random phase
    void'($urandom(32'd2024));
    for (int n = 0; n < 4000; n++) begin
      if (n % 200 == 0) begin
        srcEnable = 4'($urandom);
        retrigMode = 1'($urandom);
        gpiHold = 1'($urandom);
      end
      if ($urandom % 50 == 0) keypadLocked = ~keypadLocked;
      for (int b = 0; b < 4; b++) evtIn[b] = ($urandom % 8 == 0);
      if ($urandom % 6 == 0) begin
        clrStrobe = 1'b1; clrBits = 4'($urandom);
      end
      step();
      checkAll("R5 random (R2 R3 R8)");
    end
    finishRun();
  end
endmodule